// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the configuration front end of a multi-function I/O controller. A host issues byte reads and writes on a simple synchronous I/O bus. A key written to a key port opens configuration mode. While the block is open, an index port selects one of 42 byte-wide configuration registers, and a data port reads or writes the selected register. Outside configuration mode every read returns 0xFF and every data write is dropped.

A 16-bit strap loads two registers at reset. Bit 0 of register 0x16 (from strap bit 0) picks one of two port layouts. That bit and bit 5 of register 0x0C together set the key value. These registers are live, so a configuration write to them moves the ports or changes the key from the next bus cycle on.

The complete register file is driven out as a flat bus for the floppy, parallel and serial logic. A one-cycle change pulse for each register marks every accepted write that altered a value. Three registers are read-only. A write-lock bit freezes the whole file and hides the low registers from reads.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: When bit 0 of register 0x16 is 1, the index/key port is 0x3F0 and the data port is 0x3F1. When it is 0, the key port is 0x250, the index port is 0x251 and the data port is 0x252. Any other address has no effect and reads as 0xFF.
- R2: The key is 0x86 with the high layout and 0x88 with the low layout. Key bit 0 equals bit 5 of register 0x0C, so with reset defaults the key is 0x87 (high) or 0x89 (low).
- R3: In the high layout, two key writes in a row to 0x3F0 enter configuration mode. A single key write does not. A non-key write to 0x3F0 while closed discards a pending first key.
- R4: In the high layout in configuration mode, writing 0xAA to 0x3F0 leaves configuration mode. A value below 0x2A becomes the index. Other values leave the index unchanged.
- R5: In the low layout, writing the key to 0x250 enters configuration mode and writing any other value there leaves it. A write of 0x2A or less to 0x251 sets the index, and larger values are ignored.
- R6: A data-port write has no effect if the block is closed, if the index is 0x26, 0x27, 0x29 or not below 0x2A, or if bit 6 (write lock) of register 0x09 is set.
- R7: An accepted write to register 0x06 always stores bit 2 as 0.
- R8: In configuration mode, the index port reads the index. The data port reads the selected register, except that it returns 0xFF when the index is 0x2A or above, or when the write lock is set and the index is below 0x18. All reads return 0xFF when the block is closed or the read strobe is low.
- R9: Reset closes the block, clears the pending key and the index, and loads 0x03=0x30, 0x07=0xF5, 0x0A=0x1F, 0x0C=0x28, 0x0D=0xA3, 0x1E=0x81, 0x26=0x24, 0x27=0x25, 0x28=0x43 and 0x29=0x62. Register 0x09 gets strap[15:8] with bit 6 cleared, 0x16 gets strap[7:0], and all other registers are 0.
- R10: An accepted data write that changes register i raises chg_o[i] for exactly one cycle. The pulse appears in the same cycle as the new value on regs_o. No pulse is raised when the value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | I/O port address |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address and state |
| strap_i | input | 16 | Reset values for registers 0x09 (high byte) and 0x16 (low byte) |
| regs_o | output | NREG*8 | Register file, register i at bits [8i+7:8i] |
| chg_o | output | NREG | One-cycle change pulse per register |

## Verification
Two things can land in the same cycle. One is a data write that rewrites the layout bit or the key modifier bit. The other is the first bus access decoded under the new settings, while that register's change pulse is still high. The bench provokes this with a directed case: it clears the layout bit in configuration mode, and in the very next cycle writes to the new key port. It expects the change pulse and the new-layout decode to take effect together. Random traffic biased toward key values, 0xAA and small indexes also hits these registers repeatedly. Every result is judged against a bench model of the requirements.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    localparam int NREG_DEF = 42;

    // port map for both layouts
    localparam logic [15:0] HI_IDX_PORT = 16'h03F0;
    localparam logic [15:0] HI_DAT_PORT = 16'h03F1;
    localparam logic [15:0] LO_KEY_PORT = 16'h0250;
    localparam logic [15:0] LO_IDX_PORT = 16'h0251;
    localparam logic [15:0] LO_DAT_PORT = 16'h0252;

    localparam logic [7:0] KEY_HI    = 8'h86;
    localparam logic [7:0] KEY_LO    = 8'h88;
    localparam logic [7:0] EXIT_CODE = 8'hAA;

    // indexes with special meaning
    localparam int R_PWR    = 6;    // bit 2 never stored
    localparam int R_LOCK   = 9;    // bit 6 write lock
    localparam int R_KEYMOD = 12;   // bit 5 feeds key bit 0
    localparam int R_BASE   = 22;   // bit 0 layout select
    localparam int LOCK_BIT   = 6;
    localparam int KEYMOD_BIT = 5;

    localparam logic [7:0] IDX_LIMIT  = 8'h2A;
    localparam logic [7:0] READ_GUARD = 8'h18;

    function automatic logic [7:0] reset_value(input int unsigned n, input logic [15:0] strap);
        logic [7:0] v;
        case (n)
            3:  v = 8'h30;
            7:  v = 8'hF5;
            9:  v = strap[15:8] & 8'hBF;
            10: v = 8'h1F;
            12: v = 8'h28;
            13: v = 8'hA3;
            22: v = strap[7:0];
            30: v = 8'h81;
            38: v = 8'h24;
            39: v = 8'h25;
            40: v = 8'h43;
            41: v = 8'h62;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic is_read_only(input logic [7:0] idx);
        return (idx == 8'h26) || (idx == 8'h27) || (idx == 8'h29);
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_unlock_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              base_hi_i,
    input  logic [7:0]        key_i,
    output logic              cfg_o,
    output logic [7:0]        idx_o
);

    localparam logic [ADDR_W-1:0] A_HI_IDX = ADDR_W'(HI_IDX_PORT);
    localparam logic [ADDR_W-1:0] A_LO_KEY = ADDR_W'(LO_KEY_PORT);
    localparam logic [ADDR_W-1:0] A_LO_IDX = ADDR_W'(LO_IDX_PORT);

    typedef struct packed {
        logic       cfg;
        logic       armed;   // first key seen in high layout
        logic [7:0] idx;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (base_hi_i) begin
                if (addr_i == A_HI_IDX) begin
                    if ((wdata_i == key_i) && !st_q.cfg) begin
                        if (st_q.armed) begin
                            st_d.cfg   = 1'b1;
                            st_d.armed = 1'b0;
                        end else begin
                            st_d.armed = 1'b1;
                        end
                    end else if (st_q.cfg) begin
                        if (wdata_i < IDX_LIMIT) st_d.idx = wdata_i;
                        if (wdata_i == EXIT_CODE) st_d.cfg = 1'b0;
                    end else begin
                        st_d.armed = 1'b0;
                    end
                end
            end else begin
                if (addr_i == A_LO_KEY) st_d.cfg = (wdata_i == key_i);
                if ((addr_i == A_LO_IDX) && (wdata_i <= IDX_LIMIT)) st_d.idx = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign idx_o = st_q.idx;

    AST_SINGLE_KEY_STAYS_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_hi_i && !st_q.cfg && !st_q.armed) |=> !st_q.cfg); // R3

    AST_EXIT_CODE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_hi_i && st_q.cfg && wr_i && addr_i == A_HI_IDX && wdata_i == EXIT_CODE)
        |=> !st_q.cfg); // R4

    AST_LOW_WRONG_KEY_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!base_hi_i && wr_i && addr_i == A_LO_KEY && wdata_i != key_i) |=> !st_q.cfg); // R5

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_unlock_pkg::*;
#(
    parameter int NREG = NREG_DEF
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [15:0]          strap_i,
    input  logic                 wr_i,
    input  logic [7:0]           idx_i,
    input  logic [7:0]           wdata_i,
    output logic [NREG-1:0][7:0] regs_o,
    output logic [NREG-1:0]      chg_o
);

    localparam logic [7:0] NREG_B = 8'(NREG);

    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic [NREG-1:0]      chg;
    } rf_st_t;

    rf_st_t st_d, st_q;
    logic       lock;
    logic       accept;
    logic [7:0] wval;

    assign lock = st_q.regs[R_LOCK][LOCK_BIT];

    always_comb begin
        st_d     = st_q;
        st_d.chg = '0;
        accept   = wr_i && !lock && (idx_i < NREG_B) && (idx_i < IDX_LIMIT)
                   && !is_read_only(idx_i);
        wval     = wdata_i;
        if (idx_i == 8'(R_PWR)) wval[2] = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (accept && (idx_i == 8'(i))) begin
                st_d.chg[i]  = (wval != st_q.regs[i]);
                st_d.regs[i] = wval;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREG; i++) st_q.regs[i] <= reset_value(i, strap_i);
            st_q.chg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
    assign chg_o  = st_q.chg;

    AST_CHG_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(st_q.chg)); // R10

    AST_LOCK_FREEZES_FILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock |=> $stable(st_q.regs)); // R6

    AST_PWR_BIT2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.regs[R_PWR][2]); // R7

    generate
        if (NREG > 41) begin : g_ro_chk
            AST_READ_ONLY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $stable(st_q.regs[38]) && $stable(st_q.regs[39]) && $stable(st_q.regs[41])); // R6
        end
    endgenerate

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_unlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NREG   = NREG_DEF
) (
    input  logic                 rd_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 base_hi_i,
    input  logic                 cfg_i,
    input  logic [7:0]           idx_i,
    input  logic [NREG-1:0][7:0] regs_i,
    output logic [7:0]           rdata_o
);

    localparam logic [ADDR_W-1:0] A_HI_IDX = ADDR_W'(HI_IDX_PORT);
    localparam logic [ADDR_W-1:0] A_HI_DAT = ADDR_W'(HI_DAT_PORT);
    localparam logic [ADDR_W-1:0] A_LO_IDX = ADDR_W'(LO_IDX_PORT);
    localparam logic [ADDR_W-1:0] A_LO_DAT = ADDR_W'(LO_DAT_PORT);
    localparam logic [7:0]        NREG_B   = 8'(NREG);

    logic idx_port, dat_port, hidden;

    assign idx_port = addr_i == (base_hi_i ? A_HI_IDX : A_LO_IDX);
    assign dat_port = addr_i == (base_hi_i ? A_HI_DAT : A_LO_DAT);
    assign hidden   = regs_i[R_LOCK][LOCK_BIT] && (idx_i < READ_GUARD);

    always_comb begin
        rdata_o = 8'hFF;
        if (rd_i && cfg_i) begin
            if (idx_port) begin
                rdata_o = idx_i;
            end else if (dat_port && !hidden && (idx_i < NREG_B) && (idx_i < IDX_LIMIT)) begin
                for (int i = 0; i < NREG; i++) begin
                    if (idx_i == 8'(i)) rdata_o = regs_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
    import cfg_unlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NREG   = NREG_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [15:0]       strap_i,
    output logic [NREG*8-1:0] regs_o,
    output logic [NREG-1:0]   chg_o
);

    localparam logic [ADDR_W-1:0] A_HI_DAT = ADDR_W'(HI_DAT_PORT);
    localparam logic [ADDR_W-1:0] A_LO_DAT = ADDR_W'(LO_DAT_PORT);

    logic [NREG-1:0][7:0] regs;
    logic                 base_hi;
    logic [7:0]           key;
    logic                 cfg;
    logic [7:0]           idx;
    logic                 data_wr;

    assign base_hi = regs[R_BASE][0];
    assign key     = (base_hi ? KEY_HI : KEY_LO) | {7'b0, regs[R_KEYMOD][KEYMOD_BIT]};
    assign data_wr = wr_en_i && cfg && (addr_i == (base_hi ? A_HI_DAT : A_LO_DAT));

    cfg_key_fsm #(.ADDR_W(ADDR_W)) u_key (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .base_hi_i (base_hi),
        .key_i     (key),
        .cfg_o     (cfg),
        .idx_o     (idx)
    );

    cfg_regfile #(.NREG(NREG)) u_rf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strap_i (strap_i),
        .wr_i    (data_wr),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .regs_o  (regs),
        .chg_o   (chg_o)
    );

    cfg_read_mux #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rd (
        .rd_i      (rd_en_i),
        .addr_i    (addr_i),
        .base_hi_i (base_hi),
        .cfg_i     (cfg),
        .idx_i     (idx),
        .regs_i    (regs),
        .rdata_o   (rdata_o)
    );

    assign regs_o = regs;

    AST_CLOSED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !cfg) |-> (rdata_o == 8'hFF)); // R8

    AST_CLOSED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg |=> (chg_o == '0)); // R6

endmodule

// File: tb/sim_cfg_unlock_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_unlock_ctrl;

    localparam int NR = 42;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    addr = '0;
    logic           wr = 1'b0, rd = 1'b0;
    logic [7:0]     wdata = '0;
    logic [7:0]     rdata;
    logic [15:0]    strap = 16'h0A05;
    logic [NR*8-1:0] regs;
    logic [NR-1:0]  chg;

    int n_chk = 0, n_fail = 0;

    logic [7:0]    m_regs [NR];
    logic [NR-1:0] m_chg;
    logic          m_cfg, m_arm;
    logic [7:0]    m_idx;

    always #4 clk = ~clk;

    cfg_unlock_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .strap_i(strap), .regs_o(regs), .chg_o(chg)
    );

    function automatic logic [7:0] def_val(input int n, input logic [15:0] s);
        case (n)
            3: return 8'h30;   7: return 8'hF5;   9: return s[15:8] & 8'hBF;
            10: return 8'h1F;  12: return 8'h28;  13: return 8'hA3;
            22: return s[7:0]; 30: return 8'h81;  38: return 8'h24;
            39: return 8'h25;  40: return 8'h43;  41: return 8'h62;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_key();
        return (m_regs[22][0] ? 8'h86 : 8'h88) | {7'b0, m_regs[12][5]};
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        logic hi;
        hi = m_regs[22][0];
        if (!m_cfg) return 8'hFF;
        if (a == (hi ? 16'h03F0 : 16'h0251)) return m_idx;
        if (a == (hi ? 16'h03F1 : 16'h0252)) begin
            if (m_idx >= 8'h2A) return 8'hFF;
            if (m_regs[9][6] && m_idx < 8'h18) return 8'hFF;
            return m_regs[m_idx];
        end
        return 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        int bad;
        bad = -1;
        for (int i = NR - 1; i >= 0; i--) if (regs[i*8 +: 8] !== m_regs[i]) bad = i;
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, bad, regs[bad*8 +: 8], m_regs[bad]);
        end
    endtask

    task automatic m_write(input logic [15:0] a, input logic [7:0] v);
        logic hi;
        logic [7:0] k, nv;
        hi = m_regs[22][0];
        k  = m_key();
        m_chg = '0;
        if (hi && a == 16'h03F0) begin
            if (v == k && !m_cfg) begin
                if (m_arm) begin m_cfg = 1'b1; m_arm = 1'b0; end
                else m_arm = 1'b1;
            end else if (m_cfg) begin
                if (v < 8'h2A) m_idx = v;
                if (v == 8'hAA) m_cfg = 1'b0;
            end else m_arm = 1'b0;
        end
        if (!hi && a == 16'h0250) m_cfg = (v == k);
        if (!hi && a == 16'h0251 && v <= 8'h2A) m_idx = v;
        if (m_cfg && a == (hi ? 16'h03F1 : 16'h0252) && !m_regs[9][6] && m_idx < 8'h2A
            && m_idx != 8'h26 && m_idx != 8'h27 && m_idx != 8'h29) begin
            nv = (m_idx == 8'h06) ? (v & 8'hFB) : v;
            if (nv != m_regs[m_idx]) m_chg[m_idx] = 1'b1;
            m_regs[m_idx] = nv;
        end
    endtask

    task automatic do_reset(input logic [15:0] s);
        @(negedge clk);
        strap = s; rst_n = 1'b0; wr = 1'b0; rd = 1'b0;
        for (int i = 0; i < NR; i++) m_regs[i] = def_val(i, s);
        m_chg = '0; m_cfg = 1'b0; m_arm = 1'b0; m_idx = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one write cycle; state checked just after the capturing edge
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(posedge clk);
        m_write(a, v);
        #1;
        wr = 1'b0;
        check_regs("R6");
        check("R10", 64'(chg), 64'(m_chg));
    endtask

    task automatic bus_rd(input logic [15:0] a, input string tag);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        check(tag, 64'(rdata), 64'(m_read(a)));
        rd = 1'b0;
    endtask

    task automatic rd_expect(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        check(tag, 64'(rdata), 64'(e));
        rd = 1'b0;
    endtask

    task automatic random_phase(input int n);
        logic [15:0] ports [5];
        logic [15:0] a;
        logic [7:0]  v;
        int sel;
        ports = '{16'h03F0, 16'h03F1, 16'h0250, 16'h0251, 16'h0252};
        for (int i = 0; i < n; i++) begin
            sel = $urandom_range(0, 9);
            a = (sel < 9) ? ports[sel % 5] : 16'($urandom_range(0, 16'h0400));
            sel = $urandom_range(0, 19);
            if (sel < 6)       v = 8'h86 + 8'($urandom_range(0, 3));
            else if (sel < 8)  v = 8'hAA;
            else if (sel < 15) v = 8'($urandom_range(0, 8'h2C));
            else               v = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 2) == 0) bus_rd(a, "R8");
            else bus_wr(a, v);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset(16'h0A05);
        check_regs("R9");
        check("R9", 64'(chg), 64'd0);
        rd_expect(16'h03F0, 8'hFF, "R8");
        rd_expect(16'h0251, 8'hFF, "R1");

        // R3: one key, a non-key, one key: still closed
        bus_wr(16'h03F0, 8'h87);
        rd_expect(16'h03F0, 8'hFF, "R3");
        bus_wr(16'h03F0, 8'h00);
        bus_wr(16'h03F0, 8'h87);
        rd_expect(16'h03F0, 8'hFF, "R3");
        // R2: the key without bit 0 is not accepted
        bus_wr(16'h03F0, 8'h86);
        bus_wr(16'h03F0, 8'h86);
        rd_expect(16'h03F0, 8'hFF, "R2");
        bus_wr(16'h03F0, 8'h87);
        bus_wr(16'h03F0, 8'h87);
        rd_expect(16'h03F0, 8'h00, "R3");

        // R6: read-only register
        bus_wr(16'h03F0, 8'h26);
        bus_wr(16'h03F1, 8'h55);
        rd_expect(16'h03F1, 8'h24, "R6");
        // R7 and R10
        bus_wr(16'h03F0, 8'h06);
        bus_wr(16'h03F1, 8'hFF);
        check("R7", 64'(regs[6*8 +: 8]), 64'hFB);
        check("R10", 64'(chg), 64'(1) << 6);
        bus_wr(16'h03F1, 8'hFF);
        check("R10", 64'(chg), 64'd0);
        // R4: index at the limit is refused, 0xAA closes
        bus_wr(16'h03F0, 8'h2A);
        rd_expect(16'h03F0, 8'h06, "R4");
        bus_wr(16'h03F0, 8'hAA);
        rd_expect(16'h03F0, 8'hFF, "R4");
        bus_wr(16'h03F1, 8'h12);
        check("R6", 64'(regs[6*8 +: 8]), 64'hFB);

        // move to low layout; next cycle uses the new key port while the pulse is high
        bus_wr(16'h03F0, 8'h87);
        bus_wr(16'h03F0, 8'h87);
        bus_wr(16'h03F0, 8'h16);
        bus_wr(16'h03F1, 8'h04);
        check("R10", 64'(chg), 64'(1) << 22);
        @(negedge clk);
        addr = 16'h0250; wdata = 8'h00; wr = 1'b1;
        #1;
        check("R10", 64'(chg), 64'(1) << 22);
        @(posedge clk);
        m_write(16'h0250, 8'h00);
        m_chg = '0;
        #1;
        wr = 1'b0;
        rd_expect(16'h0251, 8'hFF, "R5");
        rd_expect(16'h03F0, 8'hFF, "R1");
        bus_wr(16'h0250, 8'h89);
        rd_expect(16'h0251, 8'h16, "R5");
        bus_wr(16'h0251, 8'h2B);
        rd_expect(16'h0251, 8'h16, "R5");
        bus_wr(16'h0251, 8'h2A);
        rd_expect(16'h0252, 8'hFF, "R8");
        // write lock
        bus_wr(16'h0251, 8'h09);
        bus_wr(16'h0252, 8'h4A);
        rd_expect(16'h0252, 8'hFF, "R8");
        bus_wr(16'h0251, 8'h1E);
        rd_expect(16'h0252, 8'h81, "R8");
        bus_wr(16'h0252, 8'h00);
        rd_expect(16'h0252, 8'h81, "R6");

        random_phase(3000);
        do_reset(16'h0A04);
        check_regs("R9");
        random_phase(3000);
        do_reset(16'h4A05);
        check("R9", 64'(regs[9*8 +: 8]), 64'h0A);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule